// File: doc/BRIEF.md
# Indexed Register Window Access Unit

This unit gives a host on a simple memory bus access to a private bank of 32-bit registers through two bus-visible locations. One location holds a 32-bit pointer. The other is a four-byte view onto the internal register that the pointer currently names. Software writes the pointer first. It then reads or writes the view as often as it needs, and each of those accesses lands on the chosen internal register.

Only the lowest byte of the pointer names an internal register. Every access must carry all four byte enables, so changing a single field means reading the whole word, editing it and writing it back. A register wider than 32 bits has a separate index for each 32-bit half, and each half is written on its own. Reads return data one clock after the request, together with a valid strobe.

Top module: `idxwin_access`

## Requirements
- R1: After a synchronous active-low reset, the pointer reads as 0x0000_0000 and every internal register reads as zero through the view.
- R2: A write with byte enables 4'b1111 to the pointer location (offset 0x00) stores all 32 bits, and a read of that location returns all 32 stored bits.
- R3: Only pointer bits [7:0] choose the internal register. Bits [31:8] have no effect on which register the view shows.
- R4: A full-word write to the view location (offset 0x10) stores the data into the selected internal register. A later full-word read of the view returns that data.
- R5: An access whose byte enables are not 4'b1111 leaves the pointer and the internal registers unchanged when it is a write, and returns 0x0000_0000 when it is a read.
- R6: When pointer bits [7:0] are NUM_REGS or above, view reads return zero and view writes change no internal register.
- R7: A view write changes only the selected index. The two indices that hold the halves of a 64-bit value (10 for the low half, 11 for the high half) keep their values independently.
- R8: bus_rvalid is high in exactly the cycle after each cycle with bus_rd high. bus_rdata is zero whenever bus_rvalid is low.
- R9: Accesses to offsets other than 0x00 and 0x10 have no effect when written and return zero when read.
- R10: When a read and a write to the same location occur in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset inside the unit's address block |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; only 4'b1111 is honoured |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The bench builds the unit with ADDR_W of 8 and NUM_REGS of 12. With 12 registers, every index can be filled and read back in a short run. Pointer low bytes from 12 to 255 are then out of range, so dropped writes and zero reads can be exercised. Indices 10 and 11 serve as the two halves of a 64-bit value. The 8-bit address leaves room for unmapped offsets next to both decoded locations.

// File: rtl/idxwin_pkg.sv
// Package: shared types for the indexed register window unit.
// Assumes a 32-bit data path with four byte enables.
package idxwin_pkg;
    localparam int WORD_W = 32;
    localparam int BE_W   = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BE_W-1:0]   be_t;

    // Which bus-visible location an access targets
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_VIEW = 2'd2
    } tgt_e;

    // Decoded bus request
    typedef struct packed {
        tgt_e tgt;
        logic full;
        logic wr;
        logic rd;
    } req_t;
endpackage

// File: rtl/idxwin_decode.sv
// Module: idxwin_decode
// Classifies a bus access by target location and by whether it carries
// all four byte enables. Purely combinational. Assumes the two offsets differ.
module idxwin_decode
    import idxwin_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] PTR_OFF  = ADDR_W'('h00),
    parameter logic [ADDR_W-1:0] VIEW_OFF = ADDR_W'('h10)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  be_t               be,
    output req_t              req
);
    localparam be_t BE_ALL = '1;

    // Build the decoded request from the raw bus signals
    always_comb begin
        req.wr   = wr;
        req.rd   = rd;
        req.full = (be == BE_ALL);
        if (addr == PTR_OFF)
            req.tgt = TGT_PTR;
        else if (addr == VIEW_OFF)
            req.tgt = TGT_VIEW;
        else
            req.tgt = TGT_NONE;
    end
endmodule

// File: rtl/idxwin_pointer.sv
// Module: idxwin_pointer
// Holds the 32-bit pointer. The low byte forms the internal index, and an
// in-range flag is derived from it. Assumes NUM_REGS is 256 or less.
module idxwin_pointer
    import idxwin_pkg::*;
#(
    parameter int NUM_REGS = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  word_t      wdata,
    output word_t      ptr_q,
    output logic [7:0] idx,
    output logic       in_range
);
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    // Pointer storage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= wdata;
    end

    // Index extraction and range test
    always_comb begin
        idx      = ptr_q[7:0];
        in_range = ({1'b0, ptr_q[7:0]} < LIMIT);
    end
endmodule

// File: rtl/idxwin_regfile.sv
// Module: idxwin_regfile
// Generic bank of NUM_REGS 32-bit registers with one write port and one
// combinational read port. The read port returns zero for an index with no entry.
module idxwin_regfile
    import idxwin_pkg::*;
#(
    parameter int NUM_REGS = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  word_t      wr_data,
    input  logic [7:0] rd_idx,
    output word_t      rd_data
);
    word_t mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        localparam logic [7:0] MY_IDX = 8'(g);
        // One entry: cleared by reset, loaded when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_idx == MY_IDX))
                mem[g] <= wr_data;
        end
    end

    // Read selection across all entries
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == 8'(i))
                rd_data = mem[i];
        end
    end
endmodule

// File: rtl/idxwin_access.sv
// Module: idxwin_access (top)
// Bus front end for the indexed window unit. Decodes accesses, honours only
// full-word ones, updates the pointer or the selected register, and returns
// read data one cycle after the request. Assumes one access per cycle.
module idxwin_access
    import idxwin_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                NUM_REGS = 12,
    parameter logic [ADDR_W-1:0] PTR_OFF  = ADDR_W'('h00),
    parameter logic [ADDR_W-1:0] VIEW_OFF = ADDR_W'('h10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);
    req_t       req;
    word_t      ptr_q;
    logic [7:0] idx;
    logic       in_range;
    logic       ptr_load;
    logic       view_wr;
    word_t      rf_rdata;
    word_t      rd_next;
    word_t      rdata_q;
    logic       rvalid_q;

    idxwin_decode #(
        .ADDR_W   (ADDR_W),
        .PTR_OFF  (PTR_OFF),
        .VIEW_OFF (VIEW_OFF)
    ) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .be   (bus_be),
        .req  (req)
    );

    idxwin_pointer #(
        .NUM_REGS (NUM_REGS)
    ) u_pointer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .wdata    (bus_wdata),
        .ptr_q    (ptr_q),
        .idx      (idx),
        .in_range (in_range)
    );

    idxwin_regfile #(
        .NUM_REGS (NUM_REGS)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (view_wr),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .rd_idx  (idx),
        .rd_data (rf_rdata)
    );

    // Write qualification: full word, decoded target, view index in range
    always_comb begin
        ptr_load = req.wr && req.full && (req.tgt == TGT_PTR);
        view_wr  = req.wr && req.full && (req.tgt == TGT_VIEW) && in_range;
    end

    // Read data selection from pre-write state
    always_comb begin
        rd_next = '0;
        if (req.rd && req.full) begin
            unique case (req.tgt)
                TGT_PTR:  rd_next = ptr_q;
                TGT_VIEW: rd_next = in_range ? rf_rdata : '0;
                default:  rd_next = '0;
            endcase
        end
    end

    // Read response register: one-cycle latency, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= rd_next;
            rvalid_q <= req.rd;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/idxwin_access_chk.sv
// Module: idxwin_access_chk
// Property checker for idxwin_access, attached with bind below.
module idxwin_access_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                NUM_REGS = 12,
    parameter logic [ADDR_W-1:0] PTR_OFF  = ADDR_W'('h00),
    parameter logic [ADDR_W-1:0] VIEW_OFF = ADDR_W'('h10)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [31:0]       ptr_q
);
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    // R8
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R8
    no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R8
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == 32'h0));

    // R5
    partial_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_be != 4'hF) |=> (bus_rdata == 32'h0));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_be == 4'hF && bus_addr == PTR_OFF) |=> $stable(ptr_q));

    // R6
    out_of_range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == VIEW_OFF && {1'b0, ptr_q[7:0]} >= LIMIT)
        |=> (bus_rdata == 32'h0));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != PTR_OFF && bus_addr != VIEW_OFF)
        |=> (bus_rdata == 32'h0));
endmodule

bind idxwin_access idxwin_access_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .PTR_OFF  (PTR_OFF),
    .VIEW_OFF (VIEW_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_be     (bus_be),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .ptr_q      (ptr_q)
);

// File: tb/idxwin_access_test.sv
module idxwin_access_test;
    localparam int         ADDR_W   = 8;
    localparam int         NUM_REGS = 12;
    localparam logic [7:0] A_PTR    = 8'h00;
    localparam logic [7:0] A_VIEW   = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] exp_regs [NUM_REGS];
    logic [31:0] exp_ptr;

    always #5 clk = ~clk;

    idxwin_access #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_be = '0;
        d = bus_rvalid ? bus_rdata : 32'hBAD0_BAD0;
    endtask

    function automatic logic [31:0] pattern(input int i);
        return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0137);
    endfunction

    task automatic read_reg(input int i, output logic [31:0] d);
        bus_write(A_PTR, 32'(i), 4'hF);
        bus_read(A_VIEW, 4'hF, d);
    endtask

    task automatic check_all_regs(input string req);
        logic [31:0] d;
        for (int i = 0; i < NUM_REGS; i++) begin
            read_reg(i, d);
            check(req, d, exp_regs[i]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_PTR, 4'hF, d);
        check("R1 pointer after reset", d, 32'h0);
        check_all_regs("R1 register after reset");
        exp_ptr = 32'(NUM_REGS - 1);
    endtask

    task automatic t_pointer();
        logic [31:0] d;
        bus_write(A_PTR, 32'hA5A5_1E03, 4'hF);
        bus_read(A_PTR, 4'hF, d);
        check("R2 pointer readback", d, 32'hA5A5_1E03);
        exp_ptr = 32'hA5A5_1E03;
    endtask

    task automatic t_fill();
        for (int i = 0; i < NUM_REGS; i++) begin
            bus_write(A_PTR, 32'(i), 4'hF);
            bus_write(A_VIEW, pattern(i), 4'hF);
            exp_regs[i] = pattern(i);
        end
        check_all_regs("R4 window write/read");
    endtask

    task automatic t_low_byte();
        logic [31:0] d;
        bus_write(A_PTR, 32'hFFFF_FF05, 4'hF);
        bus_read(A_VIEW, 4'hF, d);
        check("R3 high pointer bits ignored", d, exp_regs[5]);
        bus_write(A_PTR, 32'h0000_0107, 4'hF);
        bus_read(A_VIEW, 4'hF, d);
        check("R3 bit 8 ignored", d, exp_regs[7]);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        bus_write(A_PTR, 32'h0000_0002, 4'hF);
        bus_write(A_VIEW, 32'h1234_5678, 4'h3);
        bus_read(A_VIEW, 4'hF, d);
        check("R5 partial window write dropped", d, exp_regs[2]);
        bus_read(A_VIEW, 4'hE, d);
        check("R5 partial window read zero", d, 32'h0);
        bus_write(A_PTR, 32'h0000_0009, 4'h1);
        bus_read(A_PTR, 4'hF, d);
        check("R5 partial pointer write dropped", d, 32'h0000_0002);
        bus_read(A_PTR, 4'h7, d);
        check("R5 partial pointer read zero", d, 32'h0);
    endtask

    task automatic t_range();
        logic [31:0] d;
        bus_write(A_PTR, 32'(NUM_REGS), 4'hF);
        bus_read(A_VIEW, 4'hF, d);
        check("R6 first out-of-range read zero", d, 32'h0);
        bus_write(A_VIEW, 32'hDEAD_BEEF, 4'hF);
        bus_write(A_PTR, 32'h0000_00FF, 4'hF);
        bus_write(A_VIEW, 32'hFEED_F00D, 4'hF);
        bus_read(A_VIEW, 4'hF, d);
        check("R6 index 255 read zero", d, 32'h0);
        check_all_regs("R6 registers untouched");
    endtask

    task automatic t_pair();
        logic [31:0] d;
        bus_write(A_PTR, 32'd10, 4'hF);
        bus_write(A_VIEW, 32'h1111_2222, 4'hF);
        bus_write(A_PTR, 32'd11, 4'hF);
        bus_write(A_VIEW, 32'h3333_4444, 4'hF);
        bus_write(A_PTR, 32'd10, 4'hF);
        bus_write(A_VIEW, 32'h5555_6666, 4'hF);
        exp_regs[10] = 32'h5555_6666;
        exp_regs[11] = 32'h3333_4444;
        read_reg(11, d);
        check("R7 high half kept", d, 32'h3333_4444);
        read_reg(10, d);
        check("R7 low half updated", d, 32'h5555_6666);
    endtask

    task automatic t_latency();
        @(negedge clk);
        check("R8 idle rvalid low", 32'(bus_rvalid), 32'h0);
        check("R8 idle rdata zero", bus_rdata, 32'h0);
        bus_addr = A_PTR; bus_be = 4'hF; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R8 rvalid one cycle after read", 32'(bus_rvalid), 32'h1);
        check("R8 rdata with rvalid", bus_rdata, 32'(10));
        @(negedge clk);
        check("R8 rvalid drops", 32'(bus_rvalid), 32'h0);
        check("R8 rdata zero after", bus_rdata, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(A_PTR, 32'd4, 4'hF);
        bus_write(8'h04, 32'h0BAD_0BAD, 4'hF);
        bus_write(8'h14, 32'h0BAD_1BAD, 4'hF);
        bus_read(8'h04, 4'hF, d);
        check("R9 unmapped read zero", d, 32'h0);
        bus_read(A_PTR, 4'hF, d);
        check("R9 pointer untouched", d, 32'd4);
        check_all_regs("R9 registers untouched");
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        bus_write(A_PTR, 32'd3, 4'hF);
        @(negedge clk);
        bus_addr = A_VIEW; bus_be = 4'hF; bus_wdata = 32'h7777_8888;
        bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
        check("R10 read sees old value", bus_rdata, exp_regs[3]);
        exp_regs[3] = 32'h7777_8888;
        bus_read(A_VIEW, 4'hF, d);
        check("R10 write then lands", d, 32'h7777_8888);
    endtask

    initial begin
        for (int i = 0; i < NUM_REGS; i++) exp_regs[i] = '0;
        exp_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_fill();
        t_low_byte();
        t_partial();
        t_range();
        t_pair();
        t_latency();
        t_unmapped();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule